// File: doc/BRIEF.md
# TLP to UDP Frame Encapsulator

This block sits between the transaction-layer side of a bus endpoint and a 10 Gb/s Ethernet transmit path. It accepts transaction-layer packets as a stream of 32-bit words. Each packet carries start and end markers and a sideband that tells which address window the request hit. Packets that hit the tunnelled window are held in a small store-and-forward buffer. Each held packet is then emitted as one byte-wide Ethernet frame. The frame carries an Ethernet header, an IPv4 header and a UDP header, then a 6-byte sequencing/timestamp header, then the packet bytes. Packets that hit any other window are consumed and discarded.

Outer addresses come from externally held, software-programmable register values that feed the block as inputs. The UDP destination port is chosen by the packet's tag. The block generates the sequence number itself. The timestamp is taken from a free-running cycle counter when the packet's first word is accepted. The IPv4 and UDP checksum fields are left at zero for a later stage to fill in.

Top module: `tlp_udp_encap`

## Requirements
- R1: During and right after reset, `frm_valid` is 0 and `tlp_ready` is 1.
- R2: A packet whose `tlp_win` value at its start word differs from `TUNNEL_WIN` (default 4) is accepted in full and produces no output frame. It also does not advance the sequence number.
- R3: Frame bytes 0-5 are `dst_mac` and bytes 6-11 are `src_mac`, both most significant byte first. Bytes 12-13 are 0x08,0x00. Bytes 14-33 are an IPv4 header in this byte order: 0x45, 0x00, length (2), 0x00, 0x00, 0x40, 0x00, 0x40, 0x11, 0x00, 0x00, `src_ip` (4), `dst_ip` (4).
- R4: Bytes 34-35 hold the source port `SRC_PORT` (default 0x3000). Bytes 36-37 hold the destination port 0x3000 plus the low 4 bits of the tag. The tag is bits [15:8] of the packet's second word.
- R5: For a packet of N words, the IPv4 length (bytes 16-17) is 34+4N and the UDP length (bytes 38-39) is 14+4N. The UDP checksum (bytes 40-41) is zero.
- R6: Bytes 42-43 hold the sequence number, most significant byte first. It starts at `SEQ_START` after reset and rises by one after each emitted frame.
- R7: The sequence number wraps from 0xFFFF to 0x0000.
- R8: Bytes 44-47 hold, most significant byte first, the number of clock edges between reset release and the edge at which the packet's first word was accepted.
- R9: From byte 48 on, the packet words follow in arrival order, each word sent most significant byte first. `frm_last` is 1 on the final byte only.
- R10: `tlp_ready` is 0 from the edge that accepts the end word of a tunnelled packet until the frame's last byte is taken. While `frm_valid` is 1 and `frm_ready` is 0, the data and `frm_last` hold steady.
- R11: A tunnelled packet of one word (start and end together) is sent with a destination port of 0x3000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tlp_valid | input | 1 | Packet word valid |
| tlp_ready | output | 1 | Block can take a packet word |
| tlp_data | input | 32 | Packet word |
| tlp_sop | input | 1 | First word of a packet |
| tlp_eop | input | 1 | Last word of a packet |
| tlp_win | input | WIN_W | Address window the packet hit (read with the start word) |
| src_mac | input | 48 | Outer source MAC address |
| dst_mac | input | 48 | Outer destination MAC address |
| src_ip | input | 32 | Outer source IPv4 address |
| dst_ip | input | 32 | Outer destination IPv4 address |
| frm_valid | output | 1 | Frame byte valid |
| frm_ready | input | 1 | Downstream takes the frame byte |
| frm_data | output | 8 | Frame byte |
| frm_last | output | 1 | Final byte of the frame |

## Verification
Once the end word of a tunnelled packet is accepted, the first frame byte is due in the next cycle, and `tlp_ready` drops in that same cycle. After that, one byte is due per cycle in which `frm_ready` is high. The timestamp is expected to equal the model's count of edges since reset release at the edge that takes the start word. The sequence number is expected to change only after a cycle in which the last byte was taken. The bench drives inputs on the falling edge and compares all outputs against its queue model a moment later. It updates the model as if the next rising edge had occurred, so every comparison falls exactly one register stage after the handshake that caused it. Irregular ready and valid patterns exercise stalls across the header, across the payload and on the last byte.

// File: rtl/encap_pkg.sv
`timescale 1ns/1ps
package encap_pkg;

    localparam int          HDR_BYTES   = 48;
    localparam logic [15:0] PORT_BASE   = 16'h3000;
    localparam logic [15:0] FIXED_BYTES = 16'd34;   // IPv4 20 + UDP 8 + custom 6
    localparam logic [15:0] UDP_FIXED   = 16'd14;   // UDP 8 + custom 6

    typedef enum logic {
        ST_CAPT,
        ST_EMIT
    } encap_state_e;

    typedef struct packed {
        logic [47:0] dst_mac;
        logic [47:0] src_mac;
        logic [31:0] src_ip;
        logic [31:0] dst_ip;
        logic [15:0] ip_len;
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [15:0] udp_len;
        logic [15:0] seq;
        logic [31:0] stamp;
    } hdr_fields_t;

    // Header byte at position idx (0..47), first transmitted byte at idx 0.
    function automatic logic [7:0] hdr_byte(input hdr_fields_t h, input logic [5:0] idx);
        logic [HDR_BYTES*8-1:0] flat;
        flat = {h.dst_mac, h.src_mac, 16'h0800,
                8'h45, 8'h00, h.ip_len, 16'h0000, 16'h4000, 8'h40, 8'h11, 16'h0000,
                h.src_ip, h.dst_ip,
                h.src_port, h.dst_port, h.udp_len, 16'h0000,
                h.seq, h.stamp};
        return flat[HDR_BYTES*8-1 - 8*int'(idx) -: 8];
    endfunction

endpackage

// File: rtl/encap_counter.sv
`timescale 1ns/1ps
module encap_counter #(
    parameter int          W    = 16,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= INIT;
        else if (inc) q <= q + W'(1);
    end

    // R6 R8: one step per enabled cycle, modulo 2^W (covers R7 wrap)
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        inc |=> q == $past(q) + W'(1));

    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(q));
endmodule

// File: rtl/encap_word_buf.sv
`timescale 1ns/1ps
module encap_word_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tlp_udp_encap.sv
`timescale 1ns/1ps
module tlp_udp_encap
    import encap_pkg::*;
#(
    parameter int          MAX_DW     = 32,
    parameter int          WIN_W      = 3,
    parameter int          TUNNEL_WIN = 4,
    parameter logic [15:0] SRC_PORT   = 16'h3000,
    parameter logic [15:0] SEQ_START  = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tlp_valid,
    output logic             tlp_ready,
    input  logic [31:0]      tlp_data,
    input  logic             tlp_sop,
    input  logic             tlp_eop,
    input  logic [WIN_W-1:0] tlp_win,
    input  logic [47:0]      src_mac,
    input  logic [47:0]      dst_mac,
    input  logic [31:0]      src_ip,
    input  logic [31:0]      dst_ip,
    output logic             frm_valid,
    input  logic             frm_ready,
    output logic [7:0]       frm_data,
    output logic             frm_last
);
    localparam int AW    = $clog2(MAX_DW);
    localparam int CNT_W = AW + 1;
    localparam int PB_W  = AW + 2;

    encap_state_e     state;
    logic             in_pkt;
    logic             keep;
    logic [CNT_W-1:0] nwords;
    logic [3:0]       tag_lo;
    logic [31:0]      ts_cap;
    logic             in_hdr;
    logic [5:0]       hidx;
    logic [PB_W-1:0]  pidx;

    logic [31:0]      ts_q;
    logic [15:0]      seq_q;
    logic [31:0]      rd_word;

    logic             acc, start, keep_now, active, we, seq_inc;
    logic [CNT_W-1:0] widx;
    hdr_fields_t      hf;

    // Input side
    assign tlp_ready = (state == ST_CAPT);
    assign acc       = tlp_valid && tlp_ready;
    assign start     = acc && tlp_sop;
    assign keep_now  = start ? (tlp_win == WIN_W'(TUNNEL_WIN)) : keep;
    assign active    = start || in_pkt;
    assign widx      = start ? '0 : nwords;
    assign we        = acc && active && keep_now && (widx < CNT_W'(MAX_DW));

    // Output side
    assign frm_valid = (state == ST_EMIT);
    assign frm_last  = frm_valid && !in_hdr &&
                       (pidx == PB_W'({nwords, 2'b00}) - PB_W'(1));
    assign seq_inc   = frm_valid && frm_ready && frm_last;

    encap_counter #(.W(32), .INIT(32'h0)) u_stamp (
        .clk (clk), .rst (rst), .inc (1'b1), .q (ts_q)
    );

    encap_counter #(.W(16), .INIT(SEQ_START)) u_seq (
        .clk (clk), .rst (rst), .inc (seq_inc), .q (seq_q)
    );

    encap_word_buf #(.W(32), .DEPTH(MAX_DW)) u_buf (
        .clk   (clk),
        .we    (we),
        .waddr (widx[AW-1:0]),
        .wdata (tlp_data),
        .raddr (pidx[PB_W-1:2]),
        .rdata (rd_word)
    );

    always_comb begin
        hf.dst_mac  = dst_mac;
        hf.src_mac  = src_mac;
        hf.src_ip   = src_ip;
        hf.dst_ip   = dst_ip;
        hf.ip_len   = FIXED_BYTES + 16'({nwords, 2'b00});
        hf.udp_len  = UDP_FIXED + 16'({nwords, 2'b00});
        hf.src_port = SRC_PORT;
        hf.dst_port = PORT_BASE + {12'h000, tag_lo};
        hf.seq      = seq_q;
        hf.stamp    = ts_cap;
    end

    always_comb begin
        if (in_hdr) begin
            frm_data = hdr_byte(hf, hidx);
        end else begin
            case (pidx[1:0])
                2'd0:    frm_data = rd_word[31:24];
                2'd1:    frm_data = rd_word[23:16];
                2'd2:    frm_data = rd_word[15:8];
                default: frm_data = rd_word[7:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_CAPT;
            in_pkt <= 1'b0;
            keep   <= 1'b0;
            nwords <= '0;
            tag_lo <= '0;
            ts_cap <= '0;
            in_hdr <= 1'b1;
            hidx   <= '0;
            pidx   <= '0;
        end else if (state == ST_CAPT) begin
            if (start) begin
                keep   <= keep_now;
                ts_cap <= ts_q;
                tag_lo <= '0;
            end
            if (acc && active) begin
                nwords <= (widx < CNT_W'(MAX_DW)) ? widx + CNT_W'(1) : widx;
                if (widx == CNT_W'(1)) tag_lo <= tlp_data[11:8];
                in_pkt <= !tlp_eop;
                if (tlp_eop && keep_now) begin
                    state  <= ST_EMIT;
                    in_hdr <= 1'b1;
                    hidx   <= '0;
                    pidx   <= '0;
                end
            end
        end else if (frm_ready) begin
            if (frm_last) begin
                state <= ST_CAPT;
            end else if (in_hdr) begin
                if (hidx == 6'(HDR_BYTES - 1)) in_hdr <= 1'b0;
                else                           hidx   <= hidx + 6'd1;
            end else begin
                pidx <= pidx + PB_W'(1);
            end
        end
    end

    // R10
    frm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_data) && $stable(frm_last));

    // R10
    no_take_while_emit_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> !tlp_ready);

    // R2
    drop_window_chk: assert property (@(posedge clk) disable iff (rst)
        tlp_valid && tlp_ready && tlp_sop && tlp_eop && tlp_win != WIN_W'(TUNNEL_WIN)
        |=> !frm_valid);

    // R6
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        seq_inc |=> seq_q == $past(seq_q) + 16'd1);

    // R8
    stamp_capture_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> ts_cap == $past(ts_q));
endmodule

// File: tb/tlp_udp_encap_test.sv
`timescale 1ns/1ps
module tlp_udp_encap_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tlp_valid = 1'b0, tlp_sop = 1'b0, tlp_eop = 1'b0;
    logic [31:0] tlp_data = '0;
    logic [2:0]  tlp_win = '0;
    logic        tlp_ready;
    logic [47:0] src_mac = 48'h02_11_22_33_44_55, dst_mac = 48'h0A_BB_CC_DD_EE_F0;
    logic [31:0] src_ip = 32'hC0A8_0A01, dst_ip = 32'hC0A8_0A02;
    logic        frm_valid, frm_last, frm_ready = 1'b0;
    logic [7:0]  frm_data;

    always #2.5 clk = ~clk;

    tlp_udp_encap #(.SEQ_START(16'hFFFE)) uut (
        .clk(clk), .rst(rst), .tlp_valid(tlp_valid), .tlp_ready(tlp_ready),
        .tlp_data(tlp_data), .tlp_sop(tlp_sop), .tlp_eop(tlp_eop), .tlp_win(tlp_win),
        .src_mac(src_mac), .dst_mac(dst_mac), .src_ip(src_ip), .dst_ip(dst_ip),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data), .frm_last(frm_last)
    );

    typedef struct {
        logic [31:0] d;
        logic        s;
        logic        e;
        logic [2:0]  win;
    } wd_t;

    wd_t         inq[$];
    logic [7:0]  exp_q[$];
    logic [31:0] cur_w[$];
    int          exp_pos = 0;
    bit          emitting = 0, kcur = 0, inpk = 0;
    logic [3:0]  cur_tag = '0;
    logic [31:0] cur_ts = '0;
    logic [15:0] seq_m = 16'hFFFE;
    int unsigned tick = 0;
    int          cyc = 0, errs = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int p);
        if (p < 16)      return "R3";
        else if (p < 18) return "R5";
        else if (p < 34) return "R3";
        else if (p < 38) return "R4 R11";
        else if (p < 42) return "R5";
        else if (p < 44) return "R6 R7";
        else if (p < 48) return "R8";
        else             return "R9";
    endfunction

    task automatic add_pkt(input logic [2:0] win, input logic [7:0] tag, input int n, input int id);
        for (int i = 0; i < n; i++) begin
            wd_t w;
            if (i == 0)      w.d = 32'h4000_0000 | 32'(n);
            else if (i == 1) w.d = {16'hBEEF, tag, 8'hFF};
            else             w.d = {8'(id), 8'(i), 16'hA5C3 ^ 16'(i)};
            w.s = (i == 0);
            w.e = (i == n - 1);
            w.win = win;
            inq.push_back(w);
        end
    endtask

    task automatic push16(input logic [15:0] v);
        exp_q.push_back(v[15:8]);
        exp_q.push_back(v[7:0]);
    endtask

    task automatic build_frame();
        int n = cur_w.size();
        exp_q.delete();
        for (int i = 5; i >= 0; i--) exp_q.push_back(dst_mac[i*8 +: 8]);
        for (int i = 5; i >= 0; i--) exp_q.push_back(src_mac[i*8 +: 8]);
        push16(16'h0800);
        exp_q.push_back(8'h45); exp_q.push_back(8'h00);
        push16(16'(34 + 4 * n));
        push16(16'h0000); push16(16'h4000);
        exp_q.push_back(8'h40); exp_q.push_back(8'h11);
        push16(16'h0000);
        push16(src_ip[31:16]); push16(src_ip[15:0]);
        push16(dst_ip[31:16]); push16(dst_ip[15:0]);
        push16(16'h3000);
        push16(16'h3000 + 16'(cur_tag));
        push16(16'(14 + 4 * n));
        push16(16'h0000);
        push16(seq_m);
        push16(cur_ts[31:16]); push16(cur_ts[15:0]);
        foreach (cur_w[i]) begin
            push16(cur_w[i][31:16]);
            push16(cur_w[i][15:0]);
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model past the next rising edge.
    task automatic step();
        bit iv;
        iv = (inq.size() > 0) && ((cyc % 6) != 4);
        tlp_valid = iv;
        if (iv) begin
            tlp_data = inq[0].d; tlp_sop = inq[0].s; tlp_eop = inq[0].e; tlp_win = inq[0].win;
        end else begin
            tlp_data = '0; tlp_sop = 1'b0; tlp_eop = 1'b0; tlp_win = '0;
        end
        frm_ready = !(((cyc % 9) == 3) || (((cyc / 40) % 3 == 1) && ((cyc % 4) != 0)));
        #1;
        // R10: input side held off while a frame is out
        chk(tlp_ready === !emitting, "R10", "tlp_ready", 64'(tlp_ready), 64'(!emitting));
        // R2: no frame for a packet outside the window
        chk(frm_valid === emitting, emitting ? "R10" : "R2", "frm_valid", 64'(frm_valid), 64'(emitting));
        if (emitting && frm_valid === 1'b1) begin
            chk(frm_data === exp_q[0], req_of(exp_pos), $sformatf("byte %0d", exp_pos),
                64'(frm_data), 64'(exp_q[0]));
            // R9
            chk(frm_last === (exp_q.size() == 1), "R9", "frm_last", 64'(frm_last),
                64'(exp_q.size() == 1));
        end
        if (iv && !emitting) begin
            wd_t w = inq.pop_front();
            if (w.s) begin
                kcur = (w.win == 3'd4);
                inpk = 1;
                cur_ts = tick;
                cur_tag = '0;   // R11: stays zero without a second word
                cur_w.delete();
            end
            if (inpk && kcur) begin
                if (cur_w.size() == 1) cur_tag = w.d[11:8];
                cur_w.push_back(w.d);
            end
            if (w.e) begin
                inpk = 0;
                if (kcur) begin
                    build_frame();
                    emitting = 1;
                    exp_pos = 0;
                end
            end
        end else if (emitting && frm_ready) begin
            void'(exp_q.pop_front());
            exp_pos++;
            if (exp_q.size() == 0) begin
                emitting = 0;
                seq_m = seq_m + 16'd1;   // R6 R7
            end
        end
        tick++;
        cyc++;
        @(negedge clk);
    endtask

    task automatic run_idle();
        int lim = 0;
        while ((inq.size() > 0 || emitting) && lim < 5000) begin
            step();
            lim++;
        end
        if (lim >= 5000) chk(1'b0, "R10", "stall limit", 64'(lim), 64'(0));
        repeat (5) step();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1
        chk(frm_valid === 1'b0, "R1", "frm_valid in reset", 64'(frm_valid), 64'(0));
        chk(tlp_ready === 1'b1, "R1", "tlp_ready in reset", 64'(tlp_ready), 64'(1));
        rst = 1'b0;
        #1;
        chk(frm_valid === 1'b0, "R1", "frm_valid after reset", 64'(frm_valid), 64'(0));

        add_pkt(3'd4, 8'h25, 4, 1);   // R4 R5 R8 R9
        add_pkt(3'd0, 8'h33, 3, 2);   // R2 dropped
        add_pkt(3'd4, 8'h1F, 8, 3);   // R7 wrap to 0000
        add_pkt(3'd4, 8'h00, 1, 4);   // R11 single word
        add_pkt(3'd2, 8'h41, 1, 5);   // R2 dropped, single word
        run_idle();

        src_mac = 48'h02_AA_00_00_00_07;
        dst_mac = 48'h0A_01_02_03_04_05;
        src_ip  = 32'h0A00_0005;
        dst_ip  = 32'h0A00_0009;
        add_pkt(3'd4, 8'hAC, 5, 6);   // R3 new register values
        add_pkt(3'd4, 8'h07, 2, 7);   // R4 tag in two-word packet
        run_idle();

        finish_run();
    end
endmodule